// File: doc/BRIEF.md
# Multi-stage lockable watchdog controller

This block is a register-programmed watchdog that watches a set of expiry pulses coming from up to sixteen timer channels. A four-bit selector picks one channel; every pulse from that channel counts down a period counter, and when a programmed number of pulses has been seen the watchdog period has elapsed. Each elapsed period moves an escalation sequencer one stage further. The first three stages raise level interrupts toward the local core (a normal interrupt and a fast interrupt) and toward a remote agent. The fourth stage pulses a debug reset request and the fifth stage pulses a full power-on reset request. Each of the five outputs has its own enable bit, and a disabled output stays quiet while the sequencer still walks through its stage.

Software services the watchdog by issuing a start command, which reloads the period counter and returns the sequencer to its armed stage while clearing all interrupt levels. Stopping the watchdog is protected: a disable command only takes effect when the command write comes directly after a write of the unlock key to the unlock register. Any command write uses up the unlock.

Top module: `wdt_escalator`

## Requirements
- R1: After reset all five outputs are low, the watchdog is stopped, and a read of the config register (offset 0x000) returns 0.
- R2: The config register at offset 0x000 holds source select in bits 3:0, period in bits 11:4, and enables in bits 12 (local interrupt), 13 (fast interrupt), 14 (remote interrupt), 15 (debug reset) and 16 (power-on reset); bits 31:17 read back as 0.
- R3: Writing the command register (offset 0x008) with bit 0 set starts the watchdog: the period counter is reloaded, the stage returns to armed and all interrupt levels clear; issuing it while running restarts escalation from the first stage.
- R4: A watchdog period elapses on the N-th expiry pulse of the selected source after a start or after the previous period, where N is the period field, and a period field of 0 behaves as 1.
- R5: Expiry pulses on any source other than the selected one have no effect, and no pulse has any effect while the watchdog is stopped.
- R6: The first, second and third elapsed periods set the local, fast and remote interrupt outputs respectively, each only when its enable bit is set; these outputs stay high until a start or an accepted disable.
- R7: The fourth elapsed period drives the debug reset output high for exactly one clock and the fifth drives the power-on reset output high for exactly one clock, each only when its enable bit is set.
- R8: Elapsed periods after the fifth change no output.
- R9: A write of bit 1 to the command register stops the watchdog and clears all outputs only when the previous write to the unlock register (offset 0x00C) carried 0x0000C45A with no command write in between; otherwise the disable is ignored and escalation carries on. When both command bits are written and the disable is accepted, the disable wins.
- R10: The unlock is consumed by any command-register write, and an unlock write of any other value leaves the watchdog locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr (config register, else 0) |
| tick_in | input | NUM_SRC | One expiry pulse line per timer channel |
| irq_local | output | 1 | Local interrupt level (stage 1) |
| irq_fast | output | 1 | Local fast interrupt level (stage 2) |
| irq_remote | output | 1 | Remote interrupt level (stage 3) |
| rst_debug | output | 1 | Debug reset request pulse (stage 4) |
| rst_por | output | 1 | Power-on reset request pulse (stage 5) |

## Verification
The assertions assume that each expiry pulse on tick_in is a single clock wide and that register writes are single-cycle strobes with a stable address and data, so that one pulse is one decrement and one write is one command. The bench drives every pulse and every write for exactly one cycle from the falling edge and releases it at the next falling edge, and never pulses a source in the same cycle as a command write. The period field is kept small so every escalation path, including the zero-period case and the saturation after the fifth stage, is reached in a few dozen cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W    = 32;
    localparam int PERIOD_W  = 8;
    localparam int SEL_W     = 4;
    localparam int CFG_W     = 5 + PERIOD_W + SEL_W;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

    localparam int OFS_CFG = 'h000;
    localparam int OFS_CMD = 'h008;
    localparam int OFS_UNL = 'h00C;

    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_HALT_BIT = 1;

    typedef struct packed {
        logic por;
        logic dbg;
        logic remote;
        logic fast;
        logic local_irq;
    } enables_t;

    typedef struct packed {
        enables_t              en;
        logic [PERIOD_W-1:0]   period;
        logic [SEL_W-1:0]      sel;
    } cfg_t;

    typedef enum logic [2:0] {
        STG_ARMED  = 3'd0,
        STG_LOCAL  = 3'd1,
        STG_FAST   = 3'd2,
        STG_REMOTE = 3'd3,
        STG_DEBUG  = 3'd4,
        STG_POR    = 3'd5
    } stage_t;

    function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] p);
        return (p == '0) ? PERIOD_W'(1) : p;
    endfunction

    function automatic stage_t next_stage(input stage_t s);
        stage_t n;
        case (s)
            STG_ARMED:  n = STG_LOCAL;
            STG_LOCAL:  n = STG_FAST;
            STG_FAST:   n = STG_REMOTE;
            STG_REMOTE: n = STG_DEBUG;
            default:    n = STG_POR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output cfg_t              cfg,
    output logic              go,
    output logic              halt,
    output logic              active
);

    logic wr_cfg, wr_cmd, wr_unl;
    logic armed_q;
    cfg_t cfg_q;
    logic active_q;

    assign wr_cfg = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_cmd = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_unl = bus_we && (bus_addr == ADDR_W'(OFS_UNL));

    // An accepted disable overrides a start written in the same word.
    assign halt = wr_cmd && bus_wdata[CMD_HALT_BIT] && armed_q;
    assign go   = wr_cmd && bus_wdata[CMD_GO_BIT] && !halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (wr_unl) begin
            armed_q <= (bus_wdata == UNLOCK_KEY);
        end else if (wr_cmd) begin
            armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else if (halt) begin
            active_q <= 1'b0;
        end else if (go) begin
            active_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CFG)) begin
            bus_rdata[CFG_W-1:0] = cfg_q;
        end
    end

    assign cfg    = cfg_q;
    assign active = active_q;

    // R10: any command write leaves the watchdog locked afterwards
    p_unlock_consumed_r10: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> !armed_q);

    // R9: a disable without a fresh unlock does not stop a running watchdog
    p_locked_disable_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && bus_wdata[CMD_HALT_BIT] && !armed_q && active_q) |=> active_q);

    // R9: an accepted disable always leaves the watchdog stopped
    p_unlocked_disable_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && bus_wdata[CMD_HALT_BIT] && armed_q) |=> !active_q);

endmodule

// File: rtl/wdt_period.sv
module wdt_period
    import wdt_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                go,
    input  logic                halt,
    input  logic [NUM_SRC-1:0]  tick_in,
    input  logic [SEL_W-1:0]    sel,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);

    logic [NUM_SRC-1:0]  hit;
    logic                sel_tick;
    logic [PERIOD_W-1:0] cnt_q;
    logic                counting;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = tick_in[i] && (sel == SEL_W'(i));
    end

    assign sel_tick = |hit;
    assign counting = active && !go && !halt && sel_tick;
    assign expire   = counting && (cnt_q == PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PERIOD_W'(1);
        end else if (go) begin
            cnt_q <= eff_period(period);
        end else if (counting) begin
            if (cnt_q <= PERIOD_W'(1)) begin
                cnt_q <= eff_period(period);
            end else begin
                cnt_q <= cnt_q - PERIOD_W'(1);
            end
        end
    end

    // R5: while stopped and not restarted the count is frozen
    p_idle_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (!active && !go) |=> $stable(cnt_q));

    // R4: after a period elapses the next one is a full period again
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (expire && $stable(period)) |=> (cnt_q == eff_period(period)));

endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     halt,
    input  logic     expire,
    input  enables_t en,
    output logic     irq_local,
    output logic     irq_fast,
    output logic     irq_remote,
    output logic     rst_debug,
    output logic     rst_por
);

    stage_t stage_q;
    stage_t stage_n;
    logic   l_q, f_q, r_q, d_q, p_q;

    assign stage_n = next_stage(stage_q);

    always_ff @(posedge clk) begin
        if (rst || go || halt) begin
            stage_q <= STG_ARMED;
            l_q     <= 1'b0;
            f_q     <= 1'b0;
            r_q     <= 1'b0;
            d_q     <= 1'b0;
            p_q     <= 1'b0;
        end else begin
            d_q <= 1'b0;
            p_q <= 1'b0;
            if (expire && (stage_q != STG_POR)) begin
                stage_q <= stage_n;
                case (stage_n)
                    STG_LOCAL:  l_q <= l_q | en.local_irq;
                    STG_FAST:   f_q <= f_q | en.fast;
                    STG_REMOTE: r_q <= r_q | en.remote;
                    STG_DEBUG:  d_q <= en.dbg;
                    STG_POR:    p_q <= en.por;
                    default:    ;
                endcase
            end
        end
    end

    assign irq_local  = l_q;
    assign irq_fast   = f_q;
    assign irq_remote = r_q;
    assign rst_debug  = d_q;
    assign rst_por    = p_q;

    // R7: reset requests are one clock wide
    p_por_single_r7: assert property (@(posedge clk) disable iff (rst)
        rst_por |=> !rst_por);
    p_dbg_single_r7: assert property (@(posedge clk) disable iff (rst)
        rst_debug |=> !rst_debug);

    // R7: the fifth elapsed period yields a power-on request exactly when enabled
    p_por_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (expire && !go && !halt && stage_q == STG_DEBUG) |=> (rst_por == $past(en.por)));

    // R8: the last stage is terminal until restart
    p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
        (stage_q == STG_POR && !go && !halt) |=> (stage_q == STG_POR && !rst_por && !rst_debug));

    // R6: interrupt levels only drop on a restart or an accepted disable
    p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_local && !go && !halt) |=> irq_local);

endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
    import wdt_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] tick_in,
    output logic               irq_local,
    output logic               irq_fast,
    output logic               irq_remote,
    output logic               rst_debug,
    output logic               rst_por
);

    cfg_t cfg;
    logic go, halt, active, expire;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .go        (go),
        .halt      (halt),
        .active    (active)
    );

    wdt_period #(.NUM_SRC(NUM_SRC)) u_period (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .go      (go),
        .halt    (halt),
        .tick_in (tick_in),
        .sel     (cfg.sel),
        .period  (cfg.period),
        .expire  (expire)
    );

    wdt_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .halt       (halt),
        .expire     (expire),
        .en         (cfg.en),
        .irq_local  (irq_local),
        .irq_fast   (irq_fast),
        .irq_remote (irq_remote),
        .rst_debug  (rst_debug),
        .rst_por    (rst_por)
    );

    // R1: nothing is raised while stopped and not being started
    p_quiet_when_stopped_r1: assert property (@(posedge clk) disable iff (rst)
        (!active && !go) |=> !(rst_por || rst_debug));

endmodule

// File: tb/wdt_escalator_tb_top.sv
module wdt_escalator_tb_top;

    localparam int ADDR_W  = 12;
    localparam int NUM_SRC = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_we = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [NUM_SRC-1:0] tick_in = '0;
    logic               irq_local, irq_fast, irq_remote, rst_debug, rst_por;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    wdt_escalator #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .irq_local(irq_local), .irq_fast(irq_fast), .irq_remote(irq_remote),
        .rst_debug(rst_debug), .rst_por(rst_por)
    );

    typedef struct packed {
        logic [7:0] per;
        logic [3:0] src;
        logic [7:0] n;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{per: 8'd1, src: 4'd0,  n: 8'd1},
        '{per: 8'd3, src: 4'd5,  n: 8'd3},
        '{per: 8'd0, src: 4'd9,  n: 8'd1},
        '{per: 8'd7, src: 4'd15, n: 8'd7},
        '{per: 8'd2, src: 4'd2,  n: 8'd2},
        '{per: 8'd4, src: 4'd11, n: 8'd4}
    };

    localparam logic [31:0] EN_ALL = 32'h1F000;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {rst_por, rst_debug, irq_remote, irq_fast, irq_local};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] m);
        @(negedge clk);
        tick_in = m;
        @(negedge clk);
        tick_in = '0;
    endtask

    task automatic cfg_start(input logic [31:0] c);
        wr(12'h000, c);
        wr(12'h008, 32'h1);
    endtask

    task automatic unlock_stop();
        wr(12'h00C, 32'h0000C45A);
        wr(12'h008, 32'h2);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs", {27'd0, outs()}, 32'd0);
        check("R1 cfg read", bus_rdata, 32'd0);
        pulse(16'hFFFF);
        check("R1 no start, ticks ignored", {27'd0, outs()}, 32'd0);

        // R2: config layout and readback
        wr(12'h000, 32'hFFFF_FFFF);
        check("R2 readback masks 31:17", bus_rdata, 32'h0001_FFFF);
        wr(12'h000, 32'h0000_A5C3);
        check("R2 readback value", bus_rdata, 32'h0000_A5C3);

        // R4: period table, local interrupt enabled only
        for (int k = 0; k < 6; k++) begin
            cfg_start(32'h1000 | (32'(VEC[k].per) << 4) | 32'(VEC[k].src));
            for (int t = 1; t < int'(VEC[k].n); t++) begin
                pulse(NUM_SRC'(1) << VEC[k].src);
            end
            check($sformatf("R4 vec%0d before last tick", k), {31'd0, irq_local}, 32'd0);
            pulse(NUM_SRC'(1) << VEC[k].src);
            check($sformatf("R4 vec%0d on last tick", k), {31'd0, irq_local}, 32'd1);
        end

        // R5: other sources ignored
        cfg_start(32'h1000 | (32'd2 << 4) | 32'd3);
        for (int t = 0; t < 5; t++) pulse(16'hFFF7);
        pulse(16'h0008);
        check("R5 foreign sources ignored", {31'd0, irq_local}, 32'd0);
        pulse(16'h0008);
        check("R5 selected source counts", {31'd0, irq_local}, 32'd1);

        // R6 R7 R8: full escalation, all enabled, period 1 on source 0
        cfg_start(EN_ALL | (32'd1 << 4));
        check("R3 start clears levels", {27'd0, outs()}, 32'd0);
        pulse(16'h1);
        check("R6 stage1", {27'd0, outs()}, 32'b00001);
        pulse(16'h1);
        check("R6 stage2", {27'd0, outs()}, 32'b00011);
        pulse(16'h1);
        check("R6 stage3", {27'd0, outs()}, 32'b00111);
        pulse(16'h1);
        check("R7 debug pulse", {27'd0, outs()}, 32'b01111);
        @(negedge clk);
        check("R7 debug one clock", {27'd0, outs()}, 32'b00111);
        pulse(16'h1);
        check("R7 por pulse", {27'd0, outs()}, 32'b10111);
        @(negedge clk);
        check("R7 por one clock", {27'd0, outs()}, 32'b00111);
        pulse(16'h1);
        pulse(16'h1);
        check("R8 saturated", {27'd0, outs()}, 32'b00111);

        // R6 R7: gating, only fast and por enabled (bits 13 and 16)
        cfg_start(32'h12000 | (32'd1 << 4));
        pulse(16'h1);
        check("R6 local gated", {27'd0, outs()}, 32'b00000);
        pulse(16'h1);
        check("R6 fast enabled", {27'd0, outs()}, 32'b00010);
        pulse(16'h1);
        check("R6 remote gated", {27'd0, outs()}, 32'b00010);
        pulse(16'h1);
        check("R7 debug gated", {27'd0, outs()}, 32'b00010);
        pulse(16'h1);
        check("R7 por enabled", {27'd0, outs()}, 32'b10010);

        // R3: restart mid-escalation
        cfg_start(EN_ALL | (32'd1 << 4));
        pulse(16'h1);
        pulse(16'h1);
        wr(12'h008, 32'h1);
        check("R3 restart clears", {27'd0, outs()}, 32'd0);
        pulse(16'h1);
        check("R3 back to stage1", {27'd0, outs()}, 32'b00001);

        // R9: disable without unlock ignored
        wr(12'h008, 32'h2);
        pulse(16'h1);
        check("R9 locked disable ignored", {27'd0, outs()}, 32'b00011);

        // R9: unlocked disable, disable wins over start in same word
        wr(12'h00C, 32'h0000C45A);
        wr(12'h008, 32'h3);
        check("R9 unlocked disable clears", {27'd0, outs()}, 32'd0);
        for (int t = 0; t < 6; t++) pulse(16'h1);
        check("R9 R5 stopped ignores ticks", {27'd0, outs()}, 32'd0);

        // R10: unlock consumed by a command write
        cfg_start(EN_ALL | (32'd1 << 4));
        wr(12'h00C, 32'h0000C45A);
        wr(12'h008, 32'h0);
        wr(12'h008, 32'h2);
        pulse(16'h1);
        check("R10 consumed unlock", {27'd0, outs()}, 32'b00001);
        wr(12'h00C, 32'h0000C45B);
        wr(12'h008, 32'h2);
        pulse(16'h1);
        check("R10 wrong key", {27'd0, outs()}, 32'b00011);
        unlock_stop();
        check("R10 correct key after", {27'd0, outs()}, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule